// File: doc/BRIEF.md
# Reference Clock Monitor and Selector

This block supervises six candidate reference clocks that feed one digital PLL and chooses which of them the PLL should follow. Every reference is sampled in the system-clock domain. Two monitors run on each reference. An edge counter is compared, once per fixed gate window of system-clock cycles, against a programmed nominal count and tolerance. A gap counter declares loss of signal when edges stop arriving. A dedicated external loss pin per reference disqualifies that reference as well.

A reference that has been disqualified becomes eligible again only after two consecutive clean gate windows. This keeps the selection from chattering. Selection runs in one of two ways. In automatic mode the eligible reference with the lowest nonzero programmed priority wins. In override mode a programmed index is taken as is, and the result is flagged invalid when that reference is not qualified. A small synchronous write/read port holds the priorities, the monitor thresholds and the override setting.

Top module: `ref_clock_selector`

## Requirements
- R1: After reset, `sel_valid` is 0, `ref_qual` is all zero, every priority reads 0, and the nominal count, tolerance and loss limit read 16, 2 and 32.
- R2: A write on the register port is visible on `rd_data` one clock after `rd_addr` selects it. The address map is: 0 to 5 for the per-reference priority (4 bits), 6 for the nominal count, 7 for the tolerance, 8 for the loss limit, and 9 for override control (bit 8 enables the override, bits 2:0 hold the index).
- R3: At the end of each 64-cycle gate window, `ref_foff[i]` is set when the edge count of reference i differs from the nominal count by more than the tolerance, and is cleared otherwise. A larger programmed tolerance accepts a count that a smaller one rejects.
- R4: `ref_los[i]` is raised once reference i has shown no rising edge for the programmed loss limit of system-clock cycles. The reference is then dropped from qualification.
- R5: An asserted `los_pin[i]` clears `ref_qual[i]` on the next clock edge.
- R6: A reference becomes qualified only after two consecutive gate windows without frequency offset, loss of signal or an asserted loss pin. It is not qualified within the first window after it recovers.
- R7: In automatic mode the qualified reference with the lowest nonzero priority is selected, with ties going to the lower index. A priority of 0 keeps a reference out of automatic selection.
- R8: With the override enabled and the named reference qualified, `sel_idx` equals that index and `sel_valid` is 1, whatever the priorities are.
- R9: With the override enabled and the named reference disqualified or out of range, `sel_idx` still equals the named index, `sel_valid` is 0, and there is no fallback to another reference.
- R10: In automatic mode, when no qualified reference has a nonzero priority, `sel_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 6 | Reference clocks, sampled in the system-clock domain |
| los_pin | input | 6 | External loss indications, one per reference |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 16 | Registered read data |
| sel_idx | output | 3 | Index of the chosen reference |
| sel_valid | output | 1 | Chosen reference is usable |
| ref_qual | output | 6 | Per-reference qualified status |
| ref_los | output | 6 | Per-reference loss-of-signal status |
| ref_foff | output | 6 | Per-reference frequency-offset status |

## Verification
The references are driven as square waves with chosen periods. A period of four cycles matches the nominal count. A stopped reference separates loss of signal from frequency offset, and a halved rate yields a count that a tight tolerance rejects but a wide one accepts. Priorities with a tie, a zero entry and a higher value tell strict ordering apart from index tie-break and from exclusion. The recovery checks, taken inside one window and after several, separate the two-window hold-off from immediate requalification. Override is tried on a running reference, a pin-disqualified reference and an out-of-range index, which distinguishes a valid override from a silent fallback.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_NOMINAL = 4'd6;
  localparam logic [ADDR_W-1:0] A_TOL     = 4'd7;
  localparam logic [ADDR_W-1:0] A_LOSLIM  = 4'd8;
  localparam logic [ADDR_W-1:0] A_FORCE   = 4'd9;
  localparam int FORCE_EN_BIT = 8;
endpackage

// File: rtl/rcm_regs.sv
module rcm_regs
  import rcm_pkg::*;
#(
  parameter int NUM_REF = 6,
  parameter int PRIO_W  = 4,
  parameter int DATA_W  = 16,
  parameter int IDX_W   = 3,
  parameter int NOM_RST = 16,
  parameter int TOL_RST = 2,
  parameter int LOS_RST = 32
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic [NUM_REF-1:0][PRIO_W-1:0] prio_o,
  output logic [DATA_W-1:0]              nominal_o,
  output logic [DATA_W-1:0]              tol_o,
  output logic [DATA_W-1:0]              loslim_o,
  output logic                           force_en_o,
  output logic [IDX_W-1:0]               force_idx_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      prio_o      <= '0;
      nominal_o   <= DATA_W'(NOM_RST);
      tol_o       <= DATA_W'(TOL_RST);
      loslim_o    <= DATA_W'(LOS_RST);
      force_en_o  <= 1'b0;
      force_idx_o <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REF; i++)
        if (wr_addr == ADDR_W'(i)) prio_o[i] <= wr_data[PRIO_W-1:0];
      if (wr_addr == A_NOMINAL) nominal_o <= wr_data;
      if (wr_addr == A_TOL)     tol_o     <= wr_data;
      if (wr_addr == A_LOSLIM)  loslim_o  <= wr_data;
      if (wr_addr == A_FORCE) begin
        force_en_o  <= wr_data[FORCE_EN_BIT];
        force_idx_o <= wr_data[IDX_W-1:0];
      end
    end
  end

  logic [DATA_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_REF; i++)
      if (rd_addr == ADDR_W'(i)) rd_mux = DATA_W'(prio_o[i]);
    case (rd_addr)
      A_NOMINAL: rd_mux = nominal_o;
      A_TOL:     rd_mux = tol_o;
      A_LOSLIM:  rd_mux = loslim_o;
      A_FORCE: begin
        rd_mux = DATA_W'(force_idx_o);
        rd_mux[FORCE_EN_BIT] = force_en_o;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/rcm_ref_monitor.sv
module rcm_ref_monitor #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ref_i,
  input  logic             pin_i,
  input  logic             win_end_i,
  input  logic [CNT_W-1:0] nominal_i,
  input  logic [CNT_W-1:0] tol_i,
  input  logic [CNT_W-1:0] loslim_i,
  output logic             qual_o,
  output logic             los_o,
  output logic             foff_o
);
  logic [1:0]       smp;
  logic             rise;
  logic [CNT_W-1:0] edge_cnt;
  logic [CNT_W-1:0] gap_cnt;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] dev;
  logic             bad_now;
  logic [1:0]       clean_cnt;

  assign rise    = smp[0] & ~smp[1];
  assign total   = edge_cnt + CNT_W'(rise);
  assign dev     = (total > nominal_i) ? (total - nominal_i) : (nominal_i - total);
  assign bad_now = dev > tol_i;
  assign los_o   = gap_cnt >= loslim_i;
  assign qual_o  = clean_cnt == 2'd2;

  always_ff @(posedge clk) begin
    if (rst) begin
      smp      <= '0;
      edge_cnt <= '0;
      gap_cnt  <= '0;
      foff_o   <= 1'b0;
    end else begin
      smp <= {smp[0], ref_i};
      if (rise)               gap_cnt <= '0;
      else if (gap_cnt != '1) gap_cnt <= gap_cnt + 1'b1;
      if (win_end_i) begin
        edge_cnt <= '0;
        foff_o   <= bad_now;
      end else begin
        edge_cnt <= total;
      end
    end
  end

  // two clean windows in a row before the reference is usable
  always_ff @(posedge clk) begin
    if (rst)                   clean_cnt <= '0;
    else if (pin_i || los_o)   clean_cnt <= '0;
    else if (win_end_i) begin
      if (bad_now)             clean_cnt <= '0;
      else if (clean_cnt != 2) clean_cnt <= clean_cnt + 1'b1;
    end
  end

  p_pin_clears_r5: assert property (@(posedge clk) disable iff (rst)
    pin_i |=> !qual_o);
  p_qual_at_window_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(qual_o) |-> $past(win_end_i));
  p_foff_window_only_r3: assert property (@(posedge clk) disable iff (rst)
    !win_end_i |=> $stable(foff_o));
endmodule

// File: rtl/rcm_select.sv
module rcm_select #(
  parameter int NUM_REF = 6,
  parameter int PRIO_W  = 4,
  parameter int IDX_W   = 3
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [NUM_REF-1:0]             qual_i,
  input  logic [NUM_REF-1:0][PRIO_W-1:0] prio_i,
  input  logic                           force_en_i,
  input  logic [IDX_W-1:0]               force_idx_i,
  output logic [IDX_W-1:0]               sel_idx_o,
  output logic                           sel_valid_o
);
  logic              best_hit;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_prio;
  logic              force_ok;

  always_comb begin
    best_hit  = 1'b0;
    best_idx  = '0;
    best_prio = '1;
    force_ok  = 1'b0;
    for (int i = 0; i < NUM_REF; i++) begin
      if (qual_i[i] && prio_i[i] != '0 && (!best_hit || prio_i[i] < best_prio)) begin
        best_hit  = 1'b1;
        best_idx  = IDX_W'(i);
        best_prio = prio_i[i];
      end
      if (force_idx_i == IDX_W'(i)) force_ok = qual_i[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_idx_o   <= '0;
      sel_valid_o <= 1'b0;
    end else if (force_en_i) begin
      sel_idx_o   <= force_idx_i;
      sel_valid_o <= force_ok;
    end else begin
      sel_idx_o   <= best_idx;
      sel_valid_o <= best_hit;
    end
  end

  p_forced_index_r9: assert property (@(posedge clk) disable iff (rst)
    $past(force_en_i) |-> sel_idx_o == $past(force_idx_i));
endmodule

// File: rtl/ref_clock_selector.sv
module ref_clock_selector
  import rcm_pkg::*;
#(
  parameter int NUM_REF     = 6,
  parameter int PRIO_W      = 4,
  parameter int DATA_W      = 16,
  parameter int WIN_CYCLES  = 64,
  parameter int NOM_RST     = 16,
  parameter int TOL_RST     = 2,
  parameter int LOS_RST     = 32,
  localparam int IDX_W      = $clog2(NUM_REF),
  localparam int WIN_W      = $clog2(WIN_CYCLES)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_REF-1:0] ref_in,
  input  logic [NUM_REF-1:0] los_pin,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic [ADDR_W-1:0]  rd_addr,
  output logic [DATA_W-1:0]  rd_data,
  output logic [IDX_W-1:0]   sel_idx,
  output logic               sel_valid,
  output logic [NUM_REF-1:0] ref_qual,
  output logic [NUM_REF-1:0] ref_los,
  output logic [NUM_REF-1:0] ref_foff
);
  logic [NUM_REF-1:0][PRIO_W-1:0] prio;
  logic [DATA_W-1:0]              nominal, tol, loslim;
  logic                           force_en;
  logic [IDX_W-1:0]               force_idx;
  logic [WIN_W-1:0]               win_cnt;
  logic                           win_end;

  assign win_end = win_cnt == WIN_W'(WIN_CYCLES - 1);

  always_ff @(posedge clk) begin
    if (rst || win_end) win_cnt <= '0;
    else                win_cnt <= win_cnt + 1'b1;
  end

  rcm_regs #(
    .NUM_REF(NUM_REF), .PRIO_W(PRIO_W), .DATA_W(DATA_W), .IDX_W(IDX_W),
    .NOM_RST(NOM_RST), .TOL_RST(TOL_RST), .LOS_RST(LOS_RST)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .prio_o(prio), .nominal_o(nominal),
    .tol_o(tol), .loslim_o(loslim), .force_en_o(force_en), .force_idx_o(force_idx)
  );

  for (genvar g = 0; g < NUM_REF; g++) begin : g_mon
    rcm_ref_monitor #(.CNT_W(DATA_W)) u_mon (
      .clk(clk), .rst(rst), .ref_i(ref_in[g]), .pin_i(los_pin[g]),
      .win_end_i(win_end), .nominal_i(nominal), .tol_i(tol), .loslim_i(loslim),
      .qual_o(ref_qual[g]), .los_o(ref_los[g]), .foff_o(ref_foff[g])
    );
  end

  rcm_select #(.NUM_REF(NUM_REF), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_sel (
    .clk(clk), .rst(rst), .qual_i(ref_qual), .prio_i(prio),
    .force_en_i(force_en), .force_idx_i(force_idx),
    .sel_idx_o(sel_idx), .sel_valid_o(sel_valid)
  );

  p_valid_needs_qual_r8: assert property (@(posedge clk) disable iff (rst)
    sel_valid |-> $past(ref_qual) != '0);
endmodule

// File: tb/sim_ref_clock_selector.sv
module sim_ref_clock_selector;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  ref_in = '0;
  logic [5:0]  los_pin = '0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic [2:0]  sel_idx;
  logic        sel_valid;
  logic [5:0]  ref_qual, ref_los, ref_foff;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;
  int half [6] = '{2, 2, 2, 2, 2, 2};
  int phase [6] = '{0, 0, 0, 0, 0, 0};

  always #10 clk = ~clk;

  ref_clock_selector u0 (
    .clk(clk), .rst(rst), .ref_in(ref_in), .los_pin(los_pin),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sel_idx(sel_idx),
    .sel_valid(sel_valid), .ref_qual(ref_qual), .ref_los(ref_los), .ref_foff(ref_foff)
  );

  initial begin
    forever begin
      @(negedge clk);
      for (int i = 0; i < 6; i++) begin
        if (half[i] != 0) begin
          if (phase[i] >= half[i] - 1) begin
            ref_in[i] = ~ref_in[i];
            phase[i] = 0;
          end else phase[i]++;
        end else ref_in[i] = 1'b0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic reg_rd(input logic [3:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    d = rd_data;
  endtask

  task automatic expect_sel(input int idx, input bit v, input string req);
    check(sel_valid == v, req, int'(sel_valid), int'(v));
    if (v || idx >= 0) check(int'(sel_idx) == idx, req, int'(sel_idx), idx);
  endtask

  task automatic t_reset;
    logic [15:0] d;
    check(sel_valid == 1'b0, "R1 valid", int'(sel_valid), 0);
    check(ref_qual == 6'd0, "R1 qual", int'(ref_qual), 0);
    reg_rd(4'd3, d);  check(d == 16'd0,  "R1 prio", int'(d), 0);
    reg_rd(4'd6, d);  check(d == 16'd16, "R1 nominal", int'(d), 16);
    reg_rd(4'd7, d);  check(d == 16'd2,  "R1 tol", int'(d), 2);
    reg_rd(4'd8, d);  check(d == 16'd32, "R1 loslim", int'(d), 32);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    reg_wr(4'd0, 16'd3);
    reg_wr(4'd1, 16'd2);
    reg_wr(4'd2, 16'd2);
    reg_rd(4'd0, d); check(d == 16'd3, "R2 prio0", int'(d), 3);
    reg_rd(4'd2, d); check(d == 16'd2, "R2 prio2", int'(d), 2);
    reg_wr(4'd9, 16'h0105);
    reg_rd(4'd9, d); check(d == 16'h0105, "R2 force", int'(d), 'h105);
    reg_wr(4'd9, 16'h0000);
  endtask

  task automatic t_holdoff_start;
    // well under two windows since reset: nothing may be qualified yet
    check(ref_qual == 6'd0, "R6 early", int'(ref_qual), 0);
    check(sel_valid == 1'b0, "R10 none eligible", int'(sel_valid), 0);
    wait_cyc(260);
    check(ref_qual == 6'h3f, "R6 qualified", int'(ref_qual), 'h3f);
    expect_sel(1, 1'b1, "R7 lowest prio, tie to lower index");
  endtask

  task automatic t_los;
    half[1] = 0;
    wait_cyc(40);
    check(ref_los[1] == 1'b1, "R4 los flag", int'(ref_los[1]), 1);
    expect_sel(2, 1'b1, "R4 fallback");
    half[1] = 2;
    wait_cyc(60);
    expect_sel(2, 1'b1, "R6 no early return");
    wait_cyc(260);
    expect_sel(1, 1'b1, "R6 return after two windows");
  endtask

  task automatic t_pin;
    los_pin[1] = 1'b1;
    wait_cyc(1);
    check(ref_qual[1] == 1'b0, "R5 pin clears", int'(ref_qual[1]), 0);
    wait_cyc(2);
    expect_sel(2, 1'b1, "R5 pin fallback");
    los_pin[1] = 1'b0;
    wait_cyc(260);
    expect_sel(1, 1'b1, "R5 recovered");
  endtask

  task automatic t_freq;
    half[1] = 4;
    wait_cyc(140);
    check(ref_foff[1] == 1'b1, "R3 offset flagged", int'(ref_foff[1]), 1);
    check(ref_foff[2] == 1'b0, "R3 on-rate clean", int'(ref_foff[2]), 0);
    expect_sel(2, 1'b1, "R3 offset fallback");
    reg_wr(4'd7, 16'd10);
    wait_cyc(260);
    check(ref_foff[1] == 1'b0, "R3 wider tolerance", int'(ref_foff[1]), 0);
    expect_sel(1, 1'b1, "R3 requalified");
  endtask

  task automatic t_prio_zero;
    reg_wr(4'd1, 16'd0);
    wait_cyc(3);
    expect_sel(2, 1'b1, "R7 zero priority excluded");
  endtask

  task automatic t_force;
    reg_wr(4'd9, 16'h0104);
    wait_cyc(3);
    expect_sel(4, 1'b1, "R8 override taken");
    los_pin[4] = 1'b1;
    wait_cyc(3);
    expect_sel(4, 1'b0, "R9 override on disqualified");
    reg_wr(4'd9, 16'h0106);
    wait_cyc(3);
    expect_sel(6, 1'b0, "R9 override out of range");
    reg_wr(4'd9, 16'h0000);
    los_pin[4] = 1'b0;
    wait_cyc(3);
    expect_sel(2, 1'b1, "R7 auto resumes");
  endtask

  task automatic t_none;
    reg_wr(4'd0, 16'd0);
    reg_wr(4'd2, 16'd0);
    wait_cyc(3);
    check(sel_valid == 1'b0, "R10 all excluded", int'(sel_valid), 0);
  endtask

  initial begin
    wait_cyc(5);
    rst = 1'b0;
    wait_cyc(1);
    t_reset();
    t_regs();
    t_holdoff_start();
    t_los();
    t_pin();
    t_freq();
    t_prio_zero();
    t_force();
    t_none();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule